// File: doc/BRIEF.md
# Sample Slip/Repeat Detector

This block sits beside the sample buffer of an audio receiver whose serial output runs as a slave to an external frame clock. Two events touch the buffer. Each frame-start pulse from the incoming stream writes it. Each active edge of the output frame clock reads it. The two are not locked together, so over time the reader can take the same sample twice or miss a sample entirely. The block watches both event streams and reports when the phase between them has slipped.

Every frame-start pulse starts a short, fixed countdown. When the countdown ends, the block counts the active output-clock edges seen since the previous evaluation. One edge is normal. Two or more edges mean the reader took the stored sample again, so the block asserts a hold-previous-data indication for the output path. Zero edges mean the buffer was written twice without a read, so a frame was lost. Both abnormal cases set a sticky status flag, which software clears with a read strobe.

The output frame clock is asynchronous, so it passes through a two-stage synchronizer before edge detection. A polarity input selects whether the rising or the falling edge counts as a read.

Top module: `sample_slip_monitor`

## Requirements
- R1: After reset, `slip_flag_o` and `hold_prev_o` are both 0.
- R2: An active edge of `frame_clk_i` is a rising edge when `edge_pol_i` is 0 and a falling edge when it is 1. The input is registered through two synchronizer stages before edge detection. A level change sampled at clock edge k is therefore counted at clock edge k+2.
- R3: If two or more active edges fall in the window, the window is classified as a repeat. `slip_flag_o` becomes 1, and `hold_prev_o` becomes 1 and stays 1 until the next evaluation.
- R4: If no active edge falls in the window, the window is classified as a drop. `slip_flag_o` becomes 1 and `hold_prev_o` becomes 0.
- R5: An evaluation takes place CHECK_DLY clock edges after the edge that samples `frame_start_i` high (default 4). Outputs change only at an evaluation, and the new values are visible after that edge. A window covers the active edges after the previous evaluation, up to and including the evaluating edge.
- R6: A window with exactly one active edge is normal. `slip_flag_o` keeps its value and `hold_prev_o` becomes 0.
- R7: `rd_clr_i` sampled high clears `slip_flag_o` on that edge when no repeat or drop is declared in the same cycle.
- R8: If `rd_clr_i` and a repeat or drop fall in the same cycle, the event wins and `slip_flag_o` is 1 afterwards.
- R9: The first evaluation after reset only resets the window and arms the detector. It declares no event and leaves `hold_prev_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | One-cycle pulse marking each incoming frame start, which is when the buffer is written |
| frame_clk_i | input | 1 | Asynchronous output frame clock, whose active edge reads the buffer |
| edge_pol_i | input | 1 | 0: rising edge active, 1: falling edge active |
| rd_clr_i | input | 1 | Read strobe that clears the sticky flag |
| slip_flag_o | output | 1 | Sticky flag: a repeat or drop has occurred |
| hold_prev_o | output | 1 | Output path should re-send the previous frame's data |

## Verification
Two functions can fall in the same cycle: the read-clear of the sticky flag and the declaration of a new repeat or drop. To provoke the overlap, the bench holds the read strobe high for many frames while the output frame clock runs slower than the frame starts. Drop evaluations are then bound to land on a cycle where the clear is also active. The behavioural reference model detects each such cycle. After that edge the flag must read 1, and every cycle of the run is also compared against the model.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_REPEAT = 2'd1,
    EV_DROP   = 2'd2
  } win_event_e;
endpackage

// File: rtl/srd_frame_clk_sync.sv
module srd_frame_clk_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fclk_i,
  input  logic pol_i,
  output logic edge_o
);
  // pipe[SYNC_STAGES-1] is the synchronized level, pipe[SYNC_STAGES] is its previous value
  logic [SYNC_STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[SYNC_STAGES-1:0], fclk_i};
  end

  logic lvl_now, lvl_old;
  assign lvl_now = pipe_q[SYNC_STAGES-1];
  assign lvl_old = pipe_q[SYNC_STAGES];
  assign edge_o  = pol_i ? (lvl_old & ~lvl_now) : (~lvl_old & lvl_now);
endmodule

// File: rtl/srd_check_timer.sv
module srd_check_timer #(
  parameter int CHECK_DLY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  output logic check_o,
  output logic armed_o
);
  localparam int DW = $clog2(CHECK_DLY + 1);

  logic [DW-1:0] dly_q;
  logic          armed_q;

  assign check_o = (dly_q == DW'(1));
  assign armed_o = armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (frame_start_i)      dly_q <= DW'(CHECK_DLY);
      else if (dly_q != '0)   dly_q <= dly_q - DW'(1);
      if (check_o)            armed_q <= 1'b1;
    end
  end

  p_arm_after_check_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_o |=> armed_o);

  if (CHECK_DLY > 1) begin : g_gap
    p_no_check_after_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_i |=> !check_o);
  end
endmodule

// File: rtl/srd_window_classifier.sv
module srd_window_classifier
  import srd_pkg::*;
#(
  parameter int EDGE_SAT = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       edge_i,
  input  logic       check_i,
  input  logic       armed_i,
  output win_event_e evt_o,
  output logic       hold_o
);
  localparam int CW = $clog2(EDGE_SAT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW:0]   sum;
  logic [CW-1:0] total;
  logic          hold_q;

  assign sum   = {1'b0, cnt_q} + {{CW{1'b0}}, edge_i};
  assign total = (sum > (CW+1)'(EDGE_SAT)) ? CW'(EDGE_SAT) : sum[CW-1:0];

  always_comb begin
    evt_o = EV_NONE;
    if (check_i && armed_i) begin
      if (total == '0)             evt_o = EV_DROP;
      else if (total >= CW'(2))    evt_o = EV_REPEAT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (check_i) begin
      cnt_q  <= '0;
      hold_q <= (evt_o == EV_REPEAT);
    end else begin
      cnt_q  <= total;
    end
  end

  assign hold_o = hold_q;

  p_unarmed_no_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_i && !armed_i |=> !hold_o);
  p_no_event_off_check_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_i |-> evt_o == EV_NONE);
endmodule

// File: rtl/srd_sticky_flag.sv
module srd_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // new event beats a simultaneous clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/sample_slip_monitor.sv
module sample_slip_monitor
  import srd_pkg::*;
#(
  parameter int CHECK_DLY   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_SAT    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_start_i,
  input  logic frame_clk_i,
  input  logic edge_pol_i,
  input  logic rd_clr_i,
  output logic slip_flag_o,
  output logic hold_prev_o
);
  logic       rd_edge;
  logic       check;
  logic       armed;
  win_event_e evt;

  srd_frame_clk_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .fclk_i(frame_clk_i),
    .pol_i (edge_pol_i), .edge_o(rd_edge)
  );

  srd_check_timer #(.CHECK_DLY(CHECK_DLY)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .frame_start_i(frame_start_i),
    .check_o(check), .armed_o(armed)
  );

  srd_window_classifier #(.EDGE_SAT(EDGE_SAT)) u_class (
    .clk_i (clk_i), .rst_ni(rst_ni), .edge_i(rd_edge),
    .check_i(check), .armed_i(armed), .evt_o(evt), .hold_o(hold_prev_o)
  );

  srd_sticky_flag u_flag (
    .clk_i (clk_i), .rst_ni(rst_ni), .set_i(evt != EV_NONE),
    .clr_i (rd_clr_i), .flag_o(slip_flag_o)
  );

  p_set_on_check_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slip_flag_o) |-> $past(check));
  p_hold_on_check_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hold_prev_o) |-> $past(check));
  p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i && (evt == EV_NONE) |=> !slip_flag_o);
  p_event_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt != EV_NONE) |=> slip_flag_o);
endmodule

// File: tb/sample_slip_monitor_bench.sv
module sample_slip_monitor_bench;
  localparam int DLY   = 4;
  localparam int FRAME = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0, fclk = 1'b0, pol = 1'b0, rd_clr = 1'b0;
  logic flag, hold;

  always #2 clk = ~clk;  // 250 MHz

  sample_slip_monitor #(.CHECK_DLY(DLY)) u_sample_slip_monitor (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .frame_clk_i(fclk),
    .edge_pol_i(pol), .rd_clr_i(rd_clr), .slip_flag_o(flag), .hold_prev_o(hold)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus drivers, all on the falling edge
  bit fs_en = 0, fc_en = 0;
  int fs_cnt = 0, fc_cnt = 0, fc_half = 32;
  always @(negedge clk) begin
    if (fs_en) begin
      fs = (fs_cnt == 0);
      fs_cnt = (fs_cnt + 1) % FRAME;
    end else fs = 1'b0;
    if (fc_en) begin
      if (fc_cnt + 1 >= fc_half) begin fclk = ~fclk; fc_cnt = 0; end
      else fc_cnt++;
    end
  end

  // behavioural reference model, evaluated on the rising edge
  bit hist[$] = '{0, 0, 0, 0};
  int m_dly = 0, m_cnt = 0, tot;
  bit m_armed = 0, e_flag = 0, e_hold = 0, act_edge, chk_now, evt;
  int rep_cnt = 0, drop_cnt = 0, both_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0, 0};
      m_dly = 0; m_cnt = 0; m_armed = 0; e_flag = 0; e_hold = 0;
    end else begin
      hist.push_front(fclk);
      void'(hist.pop_back());
      act_edge = pol ? (hist[3] && !hist[2]) : (!hist[3] && hist[2]);
      chk_now = (m_dly == 1);
      if (fs) m_dly = DLY;
      else if (m_dly > 0) m_dly--;
      tot = m_cnt + int'(act_edge);
      if (tot > 2) tot = 2;
      evt = 0;
      if (chk_now) begin
        e_hold = 0;
        if (m_armed && tot == 0) begin evt = 1; drop_cnt++; end
        if (m_armed && tot >= 2) begin evt = 1; e_hold = 1; rep_cnt++; end
        m_armed = 1;
        m_cnt = 0;
      end else m_cnt = tot;
      if (evt) e_flag = 1;
      else if (rd_clr) e_flag = 0;
      if (evt && rd_clr) both_cnt++;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(flag == e_flag, "R5 flag vs model", flag, e_flag);
      chk(hold == e_hold, "R3 hold vs model", hold, e_hold);
    end
  end

  task automatic clear_flag();
    @(negedge clk) rd_clr = 1'b1;
    @(negedge clk) rd_clr = 1'b0;
  endtask

  int base;
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(flag == 0 && hold == 0, "R1 reset state", {flag, hold}, 0);

    // first frame with idle frame clock: arming only
    fs_en = 1;
    repeat (FRAME - 2) @(negedge clk);
    chk(flag == 0, "R9 first evaluation silent", flag, 0);
    chk(hold == 0, "R9 first evaluation hold", hold, 0);
    // second frame, still idle: drop at exactly DLY edges after start
    do @(posedge clk); while (!fs);
    repeat (DLY) @(negedge clk);
    chk(flag == 0, "R5 flag before delay", flag, 0);
    @(negedge clk);
    chk(flag == 1, "R5 flag at delay (drop)", flag, 1);
    chk(hold == 0, "R4 drop hold", hold, 0);
    clear_flag();
    chk(flag == 0, "R7 read clear", flag, 1'b0);

    // equal rates: steady state
    fc_half = FRAME / 2; fc_en = 1;
    repeat (4 * FRAME) @(negedge clk);
    clear_flag();
    repeat (10 * FRAME) @(negedge clk);
    chk(flag == 0, "R6 equal rate no event", flag, 0);
    chk(hold == 0, "R6 equal rate hold", hold, 0);

    // output clock faster: repeat
    fc_half = 29;
    base = rep_cnt;
    wait (rep_cnt > base);
    @(negedge clk);
    chk(flag == 1, "R3 repeat sets flag", flag, 1);
    chk(hold == 1, "R3 repeat holds data", hold, 1);
    clear_flag();
    chk(flag == e_flag, "R7 clear after repeat", flag, e_flag);

    // output clock slower: drop
    fc_half = 36;
    base = drop_cnt;
    wait (drop_cnt > base);
    @(negedge clk);
    chk(flag == 1, "R4 drop sets flag", flag, 1);
    chk(hold == 0, "R4 drop no hold", hold, 0);

    // falling edge active, faster clock
    pol = 1'b1; fc_half = 29;
    repeat (2 * FRAME) @(negedge clk);
    clear_flag();
    base = rep_cnt;
    wait (rep_cnt > base);
    @(negedge clk);
    chk(flag == 1 && hold == 1, "R2 falling-edge repeat", {flag, hold}, 3);

    // clear held during drop events
    fc_half = 36;
    @(negedge clk) rd_clr = 1'b1;
    base = both_cnt;
    wait (both_cnt > base);
    @(negedge clk);
    chk(flag == 1, "R8 event beats clear", flag, 1);
    rd_clr = 1'b0;
    repeat (FRAME) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule